// File: doc/BRIEF.md
# Segment Register Descriptor Loader and Linear Address Translator

This block keeps six segment registers. Each one has a hidden descriptor cache. The block also turns a register number and a 32-bit offset into a linear address. Software writes a 16-bit selector into one of the registers. The block then decodes the selector and picks one of two table bases, the global table or the local table. It forms the address of the descriptor entry and checks that the whole 8-byte entry lies inside the chosen table's limit. It then fetches the entry as two 32-bit reads over a plain request/valid memory port. The base, limit and attribute fields are spread across the two words, and the block reassembles them into the register's cache.

A translation request names a register and an offset. The block compares the offset against that register's effective limit. The limit counts either bytes or 4 KiB pages. If the offset is in range, the block returns the cached base plus the offset. If it is not, the block returns a fault.

A request aimed at a register whose cache is still being filled gets a busy reply, and the requester retries it later. Requests to the other registers are served as usual while a fill is running. Privilege checks, descriptor type checks and paging are not part of this block.

Top module: `segTranslate`

## Requirements
- R1: A selector's bit 2 picks the table: 0 uses `gdtBase`/`gdtLimit` and 1 uses `ldtBase`/`ldtLimit`. Bits 15:3 are the entry index, and the first descriptor read goes to table base + index*8. For example, selector 1007h with local base 00120000h reads 00121000h.
- R2: An accepted selector write raises `memReq` for exactly one cycle, in the cycle after the write, with the entry address. After `memValid` returns the low word, a second one-cycle `memReq` to entry address + 4 follows in the next cycle. `loadBusy` stays high from the cycle after the write until the cycle after the high word's `memValid`.
- R3: The cache is filled from the low word `lo` and the high word `hi`. The base is {hi[31:24], hi[7:0], lo[31:16]}. A translation gives `xlValid` and `xlAddr` = base + offset (modulo 2^32) in the cycle after `xlReq`.
- R4: The limit is {hi[19:16], lo[15:0]} and the granularity flag is hi[23]. With the flag at 0 the effective limit is that byte count. With the flag at 1 it is the limit shifted left by 12, with the low 12 bits set to 1. An offset above the effective limit gives `xlFault` instead of `xlValid`. An offset equal to the limit is valid.
- R5: If index*8+7 exceeds the chosen table limit, `loadFault` pulses for one cycle in the cycle after the write. No read is issued and the register's cache keeps its old contents. An entry that ends exactly at the limit loads normally.
- R6: A translation of the register being loaded answers `xlBusy` and not `xlValid`. Translations of other registers complete normally during the load.
- R7: A selector write while `loadBusy` is high is ignored. So is a write whose register number is 6 or 7. Neither issues a read nor raises `loadFault`, and neither changes any cache.
- R8: After reset every cache holds base 0, limit 0, granularity 0, attributes 0 and privilege 0. So offset 0 translates to 0 and offset 1 faults.
- R9: With each valid translation, `xlAttr` = {hi[23:20], hi[15:8]} of the cached descriptor and `xlRpl` = bits 1:0 of the selector that loaded it.
- R10: Register numbers 0 to 5 name the six registers. A translation naming 6 or 7 answers `xlFault`.
- R11: Each translation request gets exactly one of `xlValid`, `xlFault` or `xlBusy`, one cycle later. None of the three is raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selWrEn | input | 1 | Selector write strobe |
| selWrIdx | input | 3 | Segment register number for the write |
| selWrData | input | 16 | Selector value |
| gdtBase | input | 32 | Global table base address |
| gdtLimit | input | 16 | Global table limit (last valid byte offset) |
| ldtBase | input | 32 | Local table base address |
| ldtLimit | input | 16 | Local table limit (last valid byte offset) |
| memReq | output | 1 | One-cycle read request |
| memAddr | output | 32 | Read address, meaningful while memReq is high |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data |
| loadBusy | output | 1 | A descriptor fill is running |
| loadFault | output | 1 | One-cycle pulse: entry outside table limit |
| xlReq | input | 1 | Translation request |
| xlIdx | input | 3 | Segment register number to translate through |
| xlOffset | input | 32 | Offset within the segment |
| xlValid | output | 1 | Translation succeeded |
| xlFault | output | 1 | Offset over limit or bad register number |
| xlBusy | output | 1 | Register is being loaded; retry |
| xlAddr | output | 32 | Linear address |
| xlAttr | output | 12 | Cached flag nibble and access byte |
| xlRpl | output | 2 | Cached requested privilege level |

## Verification
Each result of the block has a fixed delay:
- Translation replies, `loadFault` and the first `memReq` all appear in the cycle after the edge that samples their stimulus.
- The second `memReq` comes in the cycle after the low word's `memValid`.

The bench drives inputs and samples outputs on falling edges, one half-cycle away from the sampling edge. Because of that, every reply is read exactly one clock after its stimulus.

The memory model stamps each request and each data beat with a cycle count. From those stamps the bench checks the one-cycle gap between the low beat and the high request, at more than one memory latency.

// File: rtl/segXlatePkg.sv
package segXlatePkg;
  localparam int LIN_W = 32;
  localparam int SEL_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LO,
    ST_WAIT_LO,
    ST_REQ_HI,
    ST_WAIT_HI
  } loadStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic startLoad;  // latch selector, register number, entry address
    logic takeLo;     // capture low descriptor word
    logic hiBeat;     // second read in flight: address + 4
    logic commit;     // high word present: write the cache
  } loadStrobeT;

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [19:0]      limit;
    logic [11:0]      attr;   // {flag nibble, access byte}; attr[11] = granularity
    logic [1:0]       rpl;
  } descCacheT;
endpackage

// File: rtl/segLoadCtrl.sv
module segLoadCtrl
  import segXlatePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selWrEn,
  input  logic       idxOk,
  input  logic       entryOk,
  input  logic       memValid,
  output loadStrobeT strobes,
  output logic       memReq,
  output logic       loadBusy,
  output logic       loadFault
);
  loadStateT state, nextState;
  logic      acceptWr;

  assign acceptWr = (state == ST_IDLE) && selWrEn && idxOk;

  always_comb begin
    nextState = state;
    strobes   = '0;
    memReq    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (acceptWr && entryOk) begin
          strobes.startLoad = 1'b1;
          nextState = ST_REQ_LO;
        end
      end
      ST_REQ_LO: begin
        memReq = 1'b1;
        nextState = ST_WAIT_LO;
      end
      ST_WAIT_LO: begin
        if (memValid) begin
          strobes.takeLo = 1'b1;
          nextState = ST_REQ_HI;
        end
      end
      ST_REQ_HI: begin
        memReq = 1'b1;
        strobes.hiBeat = 1'b1;
        nextState = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        if (memValid) begin
          strobes.commit = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      loadFault <= 1'b0;
    end else begin
      state     <= nextState;
      loadFault <= acceptWr && !entryOk;
    end
  end

  assign loadBusy = (state != ST_IDLE);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R2
  AST_LOAD_END_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loadBusy) |-> $past(memValid)); // R2
  AST_FAULT_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    loadFault |-> !memReq && !loadBusy); // R5
  AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (loadBusy && selWrEn) |=> !loadFault); // R7
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segXlatePkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  loadStrobeT       strobes,
  input  logic             loadBusy,
  input  logic [IDX_W-1:0] selWrIdx,
  input  logic [SEL_W-1:0] selWrData,
  input  logic [LIN_W-1:0] gdtBase,
  input  logic [SEL_W-1:0] gdtLimit,
  input  logic [LIN_W-1:0] ldtBase,
  input  logic [SEL_W-1:0] ldtLimit,
  input  logic [31:0]      memData,
  output logic             idxOk,
  output logic             entryOk,
  output logic [LIN_W-1:0] memAddr,
  input  logic             xlReq,
  input  logic [IDX_W-1:0] xlIdx,
  input  logic [LIN_W-1:0] xlOffset,
  output logic             xlValid,
  output logic             xlFault,
  output logic             xlBusy,
  output logic [LIN_W-1:0] xlAddr,
  output logic [11:0]      xlAttr,
  output logic [1:0]       xlRpl
);
  localparam int GRAN_SHIFT = 12;

  // Selector decode and table bound check
  logic [LIN_W-1:0] tblBase, entryAddr;
  logic [SEL_W-1:0] tblLimit, entryEnd;

  assign tblBase   = selWrData[2] ? ldtBase  : gdtBase;
  assign tblLimit  = selWrData[2] ? ldtLimit : gdtLimit;
  assign entryEnd  = {selWrData[SEL_W-1:3], 3'b111};
  assign entryOk   = (entryEnd <= tblLimit);
  assign idxOk     = (32'(selWrIdx) < NUM_SEG);
  assign entryAddr = tblBase + LIN_W'({selWrData[SEL_W-1:3], 3'b000});

  // Fill registers
  logic [IDX_W-1:0] loadIdxQ;
  logic [LIN_W-1:0] entryAddrQ;
  logic [1:0]       rplQ;
  logic [31:0]      loWordQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadIdxQ   <= '0;
      entryAddrQ <= '0;
      rplQ       <= '0;
      loWordQ    <= '0;
    end else begin
      if (strobes.startLoad) begin
        loadIdxQ   <= selWrIdx;
        entryAddrQ <= entryAddr;
        rplQ       <= selWrData[1:0];
      end
      if (strobes.takeLo) loWordQ <= memData;
    end
  end

  assign memAddr = entryAddrQ + (strobes.hiBeat ? LIN_W'(4) : LIN_W'(0));

  // Reassemble scattered fields
  descCacheT newDesc;
  always_comb begin
    newDesc.base  = {memData[31:24], memData[7:0], loWordQ[31:16]};
    newDesc.limit = {memData[19:16], loWordQ[15:0]};
    newDesc.attr  = {memData[23:20], memData[15:8]};
    newDesc.rpl   = rplQ;
  end

  descCacheT cacheQ [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_cache
    always_ff @(posedge clk) begin
      if (!rstN) cacheQ[g] <= '0;
      else if (strobes.commit && (loadIdxQ == IDX_W'(g))) cacheQ[g] <= newDesc;
    end
  end

  // Translation
  descCacheT        selDesc;
  logic             xlIdxOk, overLimit, busyHit;
  logic [LIN_W-1:0] effLimit;

  always_comb begin
    selDesc = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (xlIdx == IDX_W'(i)) selDesc = cacheQ[i];
  end

  assign xlIdxOk   = (32'(xlIdx) < NUM_SEG);
  assign effLimit  = selDesc.attr[11] ? {selDesc.limit, {GRAN_SHIFT{1'b1}}}
                                      : {{GRAN_SHIFT{1'b0}}, selDesc.limit};
  assign overLimit = (xlOffset > effLimit);
  assign busyHit   = loadBusy && (xlIdx == loadIdxQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlValid <= 1'b0;
      xlFault <= 1'b0;
      xlBusy  <= 1'b0;
      xlAddr  <= '0;
      xlAttr  <= '0;
      xlRpl   <= '0;
    end else begin
      xlValid <= xlReq && !busyHit && xlIdxOk && !overLimit;
      xlFault <= xlReq && !busyHit && (!xlIdxOk || overLimit);
      xlBusy  <= xlReq && busyHit;
      xlAddr  <= selDesc.base + xlOffset;
      xlAttr  <= selDesc.attr;
      xlRpl   <= selDesc.rpl;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xlValid, xlFault, xlBusy})); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (xlValid || xlFault || xlBusy) |-> $past(xlReq)); // R11
  AST_BUSY_SAME_REG: assert property (@(posedge clk) disable iff (!rstN)
    xlBusy |-> ($past(xlIdx) == loadIdxQ) && $past(loadBusy)); // R6
  AST_CACHE_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(loadBusy) |-> $stable(loWordQ)); // R5
endmodule

// File: rtl/segTranslate.sv
module segTranslate
  import segXlatePkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selWrEn,
  input  logic [IDX_W-1:0] selWrIdx,
  input  logic [SEL_W-1:0] selWrData,
  input  logic [LIN_W-1:0] gdtBase,
  input  logic [SEL_W-1:0] gdtLimit,
  input  logic [LIN_W-1:0] ldtBase,
  input  logic [SEL_W-1:0] ldtLimit,
  output logic             memReq,
  output logic [LIN_W-1:0] memAddr,
  input  logic             memValid,
  input  logic [31:0]      memData,
  output logic             loadBusy,
  output logic             loadFault,
  input  logic             xlReq,
  input  logic [IDX_W-1:0] xlIdx,
  input  logic [LIN_W-1:0] xlOffset,
  output logic             xlValid,
  output logic             xlFault,
  output logic             xlBusy,
  output logic [LIN_W-1:0] xlAddr,
  output logic [11:0]      xlAttr,
  output logic [1:0]       xlRpl
);
  loadStrobeT strobes;
  logic       idxOk, entryOk;

  segLoadCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .selWrEn  (selWrEn),
    .idxOk    (idxOk),
    .entryOk  (entryOk),
    .memValid (memValid),
    .strobes  (strobes),
    .memReq   (memReq),
    .loadBusy (loadBusy),
    .loadFault(loadFault)
  );

  segDatapath #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .loadBusy (loadBusy),
    .selWrIdx (selWrIdx),
    .selWrData(selWrData),
    .gdtBase  (gdtBase),
    .gdtLimit (gdtLimit),
    .ldtBase  (ldtBase),
    .ldtLimit (ldtLimit),
    .memData  (memData),
    .idxOk    (idxOk),
    .entryOk  (entryOk),
    .memAddr  (memAddr),
    .xlReq    (xlReq),
    .xlIdx    (xlIdx),
    .xlOffset (xlOffset),
    .xlValid  (xlValid),
    .xlFault  (xlFault),
    .xlBusy   (xlBusy),
    .xlAddr   (xlAddr),
    .xlAttr   (xlAttr),
    .xlRpl    (xlRpl)
  );
endmodule

// File: tb/segTranslate_bench.sv
module segTranslate_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selWrEn = 1'b0;
  logic [2:0]  selWrIdx = '0;
  logic [15:0] selWrData = '0;
  logic [31:0] gdtBase = 32'h0001_0000, ldtBase = 32'h0012_0000;
  logic [15:0] gdtLimit = 16'hFFFF, ldtLimit = 16'hFFFF;
  logic        memReq, memValid = 1'b0;
  logic [31:0] memAddr, memData = '0;
  logic        loadBusy, loadFault;
  logic        xlReq = 1'b0;
  logic [2:0]  xlIdx = '0;
  logic [31:0] xlOffset = '0;
  logic        xlValid, xlFault, xlBusy;
  logic [31:0] xlAddr;
  logic [11:0] xlAttr;
  logic [1:0]  xlRpl;

  segTranslate u_segTranslate (.*);

  initial forever #5 clk = ~clk;

  int nChecks = 0, nFail = 0;
  int memLat = 2, cyc = 0, reqCount = 0, validCount = 0;
  logic [31:0] reqAddr [4];
  int reqCyc [4], validCyc [4];
  logic [31:0] wAddr [8], wData [8];
  int nWords = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memLookup(input logic [31:0] a);
    for (int i = 0; i < nWords; i++) if (wAddr[i] == a) return wData[i];
    return 32'h0;
  endfunction

  task automatic putDesc(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    wAddr[nWords] = a;     wData[nWords] = lo; nWords++;
    wAddr[nWords] = a + 4; wData[nWords] = hi; nWords++;
  endtask

  // Memory model: serves a read memLat cycles after its request
  initial begin
    int countdown = 0;
    logic [31:0] pend = '0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      memValid = 1'b0;
      if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin
          memValid = 1'b1;
          memData = memLookup(pend);
          if (validCount < 4) validCyc[validCount] = cyc;
          validCount++;
        end
      end
      if (memReq) begin
        if (reqCount < 4) begin reqAddr[reqCount] = memAddr; reqCyc[reqCount] = cyc; end
        reqCount++;
        pend = memAddr;
        countdown = memLat;
      end
    end
  end

  task automatic clearLog();
    @(negedge clk);
    reqCount = 0; validCount = 0;
  endtask

  task automatic writeSel(input logic [2:0] idx, input logic [15:0] sel, output logic flt);
    @(negedge clk);
    selWrEn = 1'b1; selWrIdx = idx; selWrData = sel;
    @(negedge clk);
    selWrEn = 1'b0;
    flt = loadFault;
  endtask

  task automatic waitIdle();
    while (loadBusy) @(negedge clk);
  endtask

  task automatic xlate(input logic [2:0] idx, input logic [31:0] off,
                       output logic [2:0] vfb, output logic [31:0] addr);
    @(negedge clk);
    xlReq = 1'b1; xlIdx = idx; xlOffset = off;
    @(negedge clk);
    xlReq = 1'b0;
    vfb = {xlValid, xlFault, xlBusy};
    addr = xlAddr;
  endtask

  task automatic testReset();
    logic [2:0] r; logic [31:0] a;
    check(!memReq && !loadBusy && !loadFault, "R8", "idle after reset", {29'b0, memReq, loadBusy, loadFault}, 0);
    xlate(3'd0, 32'h0, r, a);
    check(r == 3'b100 && a == 0, "R8", "offset 0 of reset cache", a, 0);
    xlate(3'd0, 32'h1, r, a);
    check(r == 3'b010, "R8", "offset 1 of reset cache faults", {29'b0, r}, 3'b010);
  endtask

  task automatic testGlobalLoad();
    logic f; logic [2:0] r; logic [31:0] a;
    memLat = 2;
    clearLog();
    writeSel(3'd3, 16'h0010, f);
    check(f == 0 && loadBusy && memReq, "R2", "fetch starts next cycle", {30'b0, loadBusy, memReq}, 3);
    check(memAddr == 32'h0001_0010, "R1", "global entry address", memAddr, 32'h0001_0010);
    waitIdle();
    check(reqCount == 2, "R2", "two reads", reqCount, 2);
    check(reqAddr[1] == 32'h0001_0014, "R2", "second read address", reqAddr[1], 32'h0001_0014);
    check(reqCyc[1] == validCyc[0] + 1, "R2", "high request one cycle after low beat", reqCyc[1], validCyc[0] + 1);
    xlate(3'd3, 32'h0000_0FFF, r, a);
    check(r == 3'b100 && a == 32'h1234_6677, "R3", "base plus offset", a, 32'h1234_6677);
    check(xlAttr == 12'h492 && xlRpl == 2'd0, "R9", "attributes", {18'b0, xlAttr, xlRpl}, {18'b0, 12'h492, 2'd0});
    xlate(3'd3, 32'h0000_1000, r, a);
    check(r == 3'b010, "R4", "byte limit exceeded", {29'b0, r}, 3'b010);
  endtask

  task automatic testLocalLoad();
    logic f; logic [2:0] r; logic [31:0] a;
    memLat = 1;
    clearLog();
    writeSel(3'd1, 16'h1007, f);
    check(memAddr == 32'h0012_1000, "R1", "local entry address", memAddr, 32'h0012_1000);
    waitIdle();
    check(reqCyc[1] == validCyc[0] + 1, "R2", "high request timing at latency 1", reqCyc[1], validCyc[0] + 1);
    xlate(3'd1, 32'h0000_2000, r, a);
    check(r == 3'b100 && a == 32'h0000_1000, "R3", "address wraps", a, 32'h0000_1000);
    check(xlAttr == 12'h8F2 && xlRpl == 2'd3, "R9", "attributes and privilege", {18'b0, xlAttr, xlRpl}, {18'b0, 12'h8F2, 2'd3});
    xlate(3'd1, 32'h0000_3FFF, r, a);
    check(r == 3'b100 && a == 32'h0000_2FFF, "R4", "page limit boundary valid", a, 32'h0000_2FFF);
    xlate(3'd1, 32'h0000_4000, r, a);
    check(r == 3'b010, "R4", "page limit exceeded", {29'b0, r}, 3'b010);
  endtask

  task automatic testTableLimit();
    logic f; logic [2:0] r; logic [31:0] a;
    gdtLimit = 16'h0017;
    clearLog();
    writeSel(3'd2, 16'h0018, f);
    check(f == 1 && !loadBusy, "R5", "entry beyond limit faults", {30'b0, f, loadBusy}, 2);
    @(negedge clk);
    check(!loadFault, "R5", "fault lasts one cycle", {31'b0, loadFault}, 0);
    repeat (4) @(negedge clk);
    check(reqCount == 0, "R5", "no read on fault", reqCount, 0);
    xlate(3'd2, 32'h1, r, a);
    check(r == 3'b010, "R5", "cache unchanged after fault", {29'b0, r}, 3'b010);
    clearLog();
    writeSel(3'd3, 16'h0010, f);
    check(f == 0, "R5", "entry ending at limit accepted", {31'b0, f}, 0);
    waitIdle();
    check(reqCount == 2, "R5", "boundary entry fetched", reqCount, 2);
    gdtLimit = 16'hFFFF;
  endtask

  task automatic testBusy();
    logic f; logic [2:0] r; logic [31:0] a;
    memLat = 6;
    clearLog();
    writeSel(3'd4, 16'h0008, f);
    xlate(3'd4, 32'h4, r, a);
    check(r == 3'b001, "R6", "loading register busy", {29'b0, r}, 3'b001);
    xlate(3'd3, 32'h10, r, a);
    check(r == 3'b100 && a == 32'h1234_5688, "R6", "other register served", a, 32'h1234_5688);
    writeSel(3'd5, 16'h0010, f);
    check(f == 0, "R7", "write during load raises no fault", {31'b0, f}, 0);
    waitIdle();
    repeat (10) @(negedge clk);
    check(reqCount == 2 && !loadBusy, "R7", "write during load dropped", reqCount, 2);
    xlate(3'd4, 32'h4, r, a);
    check(r == 3'b100 && a == 32'h0040_0004, "R6", "served after load", a, 32'h0040_0004);
    xlate(3'd5, 32'h1, r, a);
    check(r == 3'b010, "R7", "dropped write left cache", {29'b0, r}, 3'b010);
  endtask

  task automatic testBadIndex();
    logic f; logic [2:0] r; logic [31:0] a;
    memLat = 2;
    clearLog();
    writeSel(3'd7, 16'h0010, f);
    check(f == 0 && !loadBusy, "R7", "register 7 write ignored", {30'b0, f, loadBusy}, 0);
    repeat (5) @(negedge clk);
    check(reqCount == 0, "R7", "no read for register 7", reqCount, 0);
    xlate(3'd6, 32'h0, r, a);
    check(r == 3'b010, "R10", "register 6 translation faults", {29'b0, r}, 3'b010);
    @(negedge clk);
    check(!xlValid && !xlFault && !xlBusy, "R11", "no reply without request", {29'b0, xlValid, xlFault, xlBusy}, 0);
  endtask

  initial begin
    putDesc(32'h0001_0010, 32'h5678_0FFF, 32'h1240_9234);
    putDesc(32'h0012_1000, 32'hF000_0003, 32'hFF80_F2FF);
    putDesc(32'h0001_0008, 32'h0000_0010, 32'h0040_9240);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGlobalLoad();
    testLocalLoad();
    testTableLimit();
    testBusy();
    testBadIndex();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: run did not finish, actual %0d expected 0", cyc);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule